// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small processor core and performs the hardware half of taking an interrupt and leaving it again. It holds a pending flag for each interrupt line, the global interrupt enable and the stack pointer. When the core reaches an instruction boundary, or is asleep, and an enabled request is waiting, the block accepts the lowest-numbered request. It then stalls the core with `busy` and pushes the three-byte return address onto a byte-wide stack memory. Finally it hands the core the vector address through a one-cycle `pcLoad` strobe.

On a return strobe the block pops the three bytes back, raises the stack pointer by three, presents the restored address through `pcLoad` and re-enables interrupts. A request accepted while the core sleeps waits for the wake-up circuit to report ready and then pays a fixed five-cycle penalty before the normal entry sequence runs. After the core sets the enable, the next instruction is always allowed to finish, even if that instruction puts the core to sleep.

Top module: `irq_seq`

## Requirements
- R1: A request is accepted only in a cycle where `busy` is low, `retStrobe` is low, `gie` is high, the post-enable shadow is clear, a pending flag is set, and either `instBoundary` or `asleep` is high. While a multi-cycle instruction runs (`instBoundary` and `asleep` both low), nothing is accepted.
- R2: For an acceptance while awake, `busy` is high in cycles 1 to 5 after the accepting cycle. `pcLoad` pulses only in cycle 5, with `pcOut` equal to the vector index times two, and `busy` is low in cycle 6. `memWe`, `memRe` and `pcLoad` are never high together.
- R3: During entry the return address `pcIn` (sampled in the accepting cycle) is written in three consecutive cycles. Byte [7:0] goes to address `stackPtr`, byte [15:8] to `stackPtr`-1 and byte [23:16] to `stackPtr`-2. `stackPtr` ends three lower.
- R4: For an acceptance while `asleep` is high, let C be the first cycle at or after acceptance in which `wakeReady` is high. `pcLoad` then falls 10 cycles after C, the three writes fall in cycles C+6 to C+8, and `busy` stays high from the cycle after acceptance through the `pcLoad` cycle.
- R5: `gie` is low from the cycle after acceptance.
- R6: Among pending requests the lowest index wins, and only its flag is cleared. Requests that arrive while others wait stay pending.
- R7: When `gieSet` is pulsed together with `instBoundary`, the next `instBoundary` cannot accept a request. A later boundary, or a later cycle with `asleep` high, can.
- R8: When `retStrobe` is pulsed while `busy` is low, `busy` is high for cycles 1 to 5. `memRe` is high in cycles 1 to 3 at addresses `stackPtr`+1, +2 and +3, and read data is returned on `memRdata` one cycle after each read. `pcLoad` pulses in cycle 5 with the restored address. In cycle 6 `stackPtr` is three higher and `gie` is high.
- R9: While `gie` is low (cleared by `gieClr`), a request stays pending and is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_VEC | Request pulses, one bit per vector |
| instBoundary | input | 1 | Last cycle of the current instruction |
| asleep | input | 1 | Core is in sleep mode |
| wakeReady | input | 1 | Wake-up start-up delay has elapsed |
| gieSet | input | 1 | Core sets global enable (issued at a boundary) |
| gieClr | input | 1 | Core clears global enable |
| retStrobe | input | 1 | Return-from-interrupt executed |
| pcIn | input | 24 | Address of the next instruction |
| memRdata | input | 8 | Stack read data, one cycle after `memRe` |
| memWe | output | 1 | Stack byte write |
| memRe | output | 1 | Stack byte read |
| memAddr | output | SP_W | Stack byte address |
| memWdata | output | 8 | Stack write data |
| pcLoad | output | 1 | Load `pcOut` into the program counter |
| pcOut | output | 24 | Vector address or restored address |
| busy | output | 1 | Stall fetch while a sequence runs |
| gie | output | 1 | Global interrupt enable |
| stackPtr | output | SP_W | Current stack pointer |

## Verification
Every result is due at a fixed cycle count after a stimulus. Pushes fall in cycles 1 to 3 after an awake acceptance and the vector load in cycle 5. Pops fall in cycles 1 to 3 after a return strobe and the restored load in cycle 5. A sleeping acceptance shifts all of this by five cycles plus however long `wakeReady` stays low. The bench drives each stimulus on a falling edge and then, on every following falling edge, compares `busy`, the strobes, the address and the data against that cycle's expected values. This catches a strobe that arrives one cycle early or late, not only a wrong value. The expected winner and the stack bytes come from a bench-side pending mask and a byte-array stack model.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PC_BYTES = 3;
  localparam int PC_W     = 8 * PC_BYTES;
  localparam int SEL_W    = $clog2(PC_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_PEN, ST_ENT, ST_RET
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             take;
    logic             push;
    logic             pop;
    logic             cap;
    logic [SEL_W-1:0] sel;
    logic             loadVec;
    logic             loadRet;
  } seqCmd_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 5,
  parameter int PEN_CYC   = 5,
  parameter int RET_CYC   = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    canTake,
  input  logic    asleep,
  input  logic    wakeReady,
  input  logic    retStrobe,
  output seqCmd_t cmd,
  output logic    busy
);
  localparam int MAXC  = (ENTRY_CYC > RET_CYC) ? ((ENTRY_CYC > PEN_CYC) ? ENTRY_CYC : PEN_CYC)
                                               : ((RET_CYC > PEN_CYC) ? RET_CYC : PEN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             goRet;

  always_comb begin
    cmd         = '0;
    goRet       = (state == ST_IDLE) && retStrobe;
    cmd.take    = (state == ST_IDLE) && !retStrobe && canTake;
    cmd.push    = (state == ST_ENT) && (cnt <= CNT_W'(PC_BYTES));
    cmd.pop     = (state == ST_RET) && (cnt <= CNT_W'(PC_BYTES));
    cmd.cap     = (state == ST_RET) && (cnt >= CNT_W'(2)) && (cnt <= CNT_W'(PC_BYTES + 1));
    cmd.loadVec = (state == ST_ENT) && (cnt == CNT_W'(ENTRY_CYC));
    cmd.loadRet = (state == ST_RET) && (cnt == CNT_W'(RET_CYC));
    if (cmd.push) cmd.sel = SEL_W'(cnt - CNT_W'(1));
    else          cmd.sel = SEL_W'(CNT_W'(PC_BYTES + 1) - cnt);
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= CNT_W'(1);
          if (goRet)         state <= ST_RET;
          else if (cmd.take) state <= !asleep ? ST_ENT : (wakeReady ? ST_PEN : ST_WAKE);
        end
        ST_WAKE: begin
          cnt <= CNT_W'(1);
          if (wakeReady) state <= ST_PEN;
        end
        ST_PEN: begin
          if (cnt == CNT_W'(PEN_CYC)) begin
            state <= ST_ENT;
            cnt   <= CNT_W'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_ENT: begin
          if (cnt == CNT_W'(ENTRY_CYC)) state <= ST_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        ST_RET: begin
          if (cnt == CNT_W'(RET_CYC)) state <= ST_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int                 NUM_VEC = 8,
  parameter int                 SP_W    = 16,
  parameter logic [SP_W-1:0]    SP_INIT = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic               instBoundary,
  input  logic               asleep,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic [PC_W-1:0]    pcIn,
  input  logic [7:0]         memRdata,
  output logic               canTake,
  output logic               memWe,
  output logic               memRe,
  output logic [SP_W-1:0]    memAddr,
  output logic [7:0]         memWdata,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic               gie,
  output logic [SP_W-1:0]    stackPtr
);
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] pend, winMask;
  logic [VEC_W-1:0]   winIdx, vecIdx;
  logic               shadow;
  logic [PC_W-1:0]    pcSave, pcRest;

  // lowest index has priority
  always_comb begin
    winIdx  = '0;
    winMask = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        winIdx  = VEC_W'(i);
        winMask = NUM_VEC'(1) << i;
      end
    end
  end

  assign canTake  = gie && !shadow && (|pend) && (instBoundary || asleep);
  assign memWe    = cmd.push;
  assign memRe    = cmd.pop;
  assign memAddr  = cmd.pop ? stackPtr + SP_W'(1) : stackPtr;
  assign memWdata = pcSave[int'(cmd.sel) * 8 +: 8];
  assign pcLoad   = cmd.loadVec || cmd.loadRet;
  assign pcOut    = cmd.loadVec ? {{(PC_W - VEC_W - 1){1'b0}}, vecIdx, 1'b0} : pcRest;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= '0;
      vecIdx   <= '0;
      pcSave   <= '0;
      pcRest   <= '0;
      gie      <= 1'b0;
      shadow   <= 1'b0;
      stackPtr <= SP_INIT;
    end else begin
      pend <= (pend | irqReq) & ~(cmd.take ? winMask : '0);
      if (cmd.take) begin
        vecIdx <= winIdx;
        pcSave <= pcIn;
      end
      if (cmd.cap) pcRest[int'(cmd.sel) * 8 +: 8] <= memRdata;
      if (cmd.push)     stackPtr <= stackPtr - SP_W'(1);
      else if (cmd.pop) stackPtr <= stackPtr + SP_W'(1);
      if (cmd.take)         gie <= 1'b0;
      else if (cmd.loadRet) gie <= 1'b1;
      else if (gieSet)      gie <= 1'b1;
      else if (gieClr)      gie <= 1'b0;
      // one instruction runs after the enable is set
      if (gieSet)            shadow <= 1'b1;
      else if (instBoundary) shadow <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int              NUM_VEC   = 8,
  parameter int              SP_W      = 16,
  parameter logic [SP_W-1:0] SP_INIT   = 16'h08FF,
  parameter int              ENTRY_CYC = 5,
  parameter int              PEN_CYC   = 5,
  parameter int              RET_CYC   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic               instBoundary,
  input  logic               asleep,
  input  logic               wakeReady,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               retStrobe,
  input  logic [23:0]        pcIn,
  input  logic [7:0]         memRdata,
  output logic               memWe,
  output logic               memRe,
  output logic [SP_W-1:0]    memAddr,
  output logic [7:0]         memWdata,
  output logic               pcLoad,
  output logic [23:0]        pcOut,
  output logic               busy,
  output logic               gie,
  output logic [SP_W-1:0]    stackPtr
);
  seqCmd_t cmd;
  logic    canTake;

  irq_seq_ctrl #(.ENTRY_CYC(ENTRY_CYC), .PEN_CYC(PEN_CYC), .RET_CYC(RET_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .canTake(canTake), .asleep(asleep),
    .wakeReady(wakeReady), .retStrobe(retStrobe), .cmd(cmd), .busy(busy)
  );

  irq_seq_dp #(.NUM_VEC(NUM_VEC), .SP_W(SP_W), .SP_INIT(SP_INIT)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .irqReq(irqReq), .instBoundary(instBoundary),
    .asleep(asleep), .gieSet(gieSet), .gieClr(gieClr), .pcIn(pcIn), .memRdata(memRdata),
    .canTake(canTake), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .pcLoad(pcLoad), .pcOut(pcOut), .gie(gie), .stackPtr(stackPtr)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int SP_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            memWe,
  input logic            memRe,
  input logic [SP_W-1:0] memAddr,
  input logic            pcLoad,
  input logic            gie,
  input logic            retStrobe,
  input logic [SP_W-1:0] stackPtr
);
  a_r2_load_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> busy);
  a_r2_load_ends: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe, pcLoad}));
  a_r3_push_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    memWe ##1 memWe |-> memAddr == $past(memAddr) - SP_W'(1));
  a_r3_push_sp_down: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> stackPtr == $past(stackPtr) - SP_W'(1));
  a_r5_gie_low_push: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !gie);
  a_r8_pop_sp_up: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> stackPtr == $past(stackPtr) + SP_W'(1));
  a_r8_ret_starts: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !busy) |=> busy);
endmodule

bind irq_seq irq_seq_chk #(.SP_W(SP_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .memWe(memWe), .memRe(memRe),
  .memAddr(memAddr), .pcLoad(pcLoad), .gie(gie), .retStrobe(retStrobe),
  .stackPtr(stackPtr)
);

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int SPW = 16;
  localparam logic [SPW-1:0] SP0 = 16'h08FF;

  logic clk = 0, rstN = 0;
  logic [NV-1:0] irqReq = '0;
  logic instBoundary = 0, asleep = 0, wakeReady = 0, gieSet = 0, gieClr = 0, retStrobe = 0;
  logic [23:0] pcIn = '0;
  logic [7:0] memRdata = '0;
  logic memWe, memRe, pcLoad, busy, gie;
  logic [SPW-1:0] memAddr, stackPtr;
  logic [7:0] memWdata;
  logic [23:0] pcOut;

  logic [7:0] stackMem [256];
  logic [NV-1:0] pendModel = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_seq #(.NUM_VEC(NV), .SP_W(SPW), .SP_INIT(SP0)) dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .instBoundary(instBoundary), .asleep(asleep),
    .wakeReady(wakeReady), .gieSet(gieSet), .gieClr(gieClr), .retStrobe(retStrobe),
    .pcIn(pcIn), .memRdata(memRdata), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .pcLoad(pcLoad), .pcOut(pcOut), .busy(busy), .gie(gie),
    .stackPtr(stackPtr)
  );

  // byte stack model, read data one cycle after the read strobe
  always @(posedge clk) begin
    if (memWe) stackMem[memAddr[7:0]] <= memWdata;
    if (memRe) memRdata <= stackMem[memAddr[7:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doEntry(input logic [NV-1:0] req, input logic [23:0] pcv,
                         input bit viaSleep, input int wakeDly, input string tag);
    int win, base, last, k;
    logic [SPW-1:0] sp0;
    @(negedge clk);
    irqReq = req;
    pendModel |= req;
    @(negedge clk);
    irqReq = '0;
    pcIn = pcv;
    win = -1;
    for (int i = NV - 1; i >= 0; i--) if (pendModel[i]) win = i;
    if (win >= 0) pendModel[win] = 1'b0;
    sp0 = stackPtr;
    if (viaSleep) begin
      asleep = 1;
      wakeReady = (wakeDly == 0);
    end else instBoundary = 1;
    base = viaSleep ? wakeDly + 5 : 0;
    last = base + 5;
    for (int n = 1; n <= last + 1; n++) begin
      @(negedge clk);
      instBoundary = 0;
      asleep = 0;
      wakeReady = (n >= wakeDly);
      check(busy == (n <= last), viaSleep ? "R4" : "R2", "busy", busy, n <= last);
      k = n - base - 1;
      check(memWe == (k >= 0 && k < 3), "R3", "memWe", memWe, k >= 0 && k < 3);
      if (memWe && k >= 0 && k < 3) begin
        check(memAddr == sp0 - SPW'(k), "R3", "push addr", memAddr, sp0 - SPW'(k));
        check(memWdata == pcv[8*k +: 8], "R3", "push byte", memWdata, pcv[8*k +: 8]);
      end
      check(pcLoad == (n == last), viaSleep ? "R4" : "R2", "pcLoad", pcLoad, n == last);
      if (pcLoad) check(pcOut == 24'(win * 2), tag, "vector", pcOut, win * 2);
      if (n == 1) check(gie == 1'b0, "R5", "gie after accept", gie, 0);
    end
    check(stackPtr == sp0 - SPW'(3), "R3", "sp after entry", stackPtr, sp0 - SPW'(3));
  endtask

  task automatic doReturn(input logic [23:0] pcExp);
    logic [SPW-1:0] sp0;
    sp0 = stackPtr;
    @(negedge clk);
    retStrobe = 1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      retStrobe = 0;
      check(busy == (n <= 5), "R8", "busy", busy, n <= 5);
      check(memRe == (n <= 3), "R8", "memRe", memRe, n <= 3);
      if (memRe && n <= 3) check(memAddr == sp0 + SPW'(n), "R8", "pop addr", memAddr, sp0 + SPW'(n));
      check(pcLoad == (n == 5), "R8", "pcLoad", pcLoad, n == 5);
      if (pcLoad) check(pcOut == pcExp, "R8", "restored pc", pcOut, pcExp);
      if (n == 6) begin
        check(gie == 1'b1, "R8", "gie after return", gie, 1);
        check(stackPtr == sp0 + SPW'(3), "R8", "sp after return", stackPtr, sp0 + SPW'(3));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] pcv;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(busy == 0 && pcLoad == 0 && memWe == 0 && memRe == 0, "R2", "reset strobes", busy, 0);
    check(gie == 0, "R9", "reset gie", gie, 0);
    check(stackPtr == SP0, "R3", "reset sp", stackPtr, SP0);

    // enable, then the following instruction ends
    instBoundary = 1; gieSet = 1;
    @(negedge clk); gieSet = 0; instBoundary = 1;
    @(negedge clk); instBoundary = 0;
    check(gie == 1, "R7", "gie after set", gie, 1);

    // sweep every vector, awake and asleep with varied wake delays
    for (int v = 0; v < NV; v++) begin
      pcv = 24'hA53C00 ^ (24'(v) * 24'h011113);
      doEntry(NV'(1) << v, pcv, v[0], v % 3, "R2");
      doReturn(pcv);
    end

    // priority among several pending
    doEntry(8'hB4, 24'h123456, 0, 0, "R6"); doReturn(24'h123456);
    doEntry(8'h01, 24'h00FF01, 0, 0, "R6"); doReturn(24'h00FF01);
    doEntry(8'h00, 24'hFEDCBA, 1, 0, "R6"); doReturn(24'hFEDCBA);
    doEntry(8'h00, 24'h0A0B0C, 0, 0, "R6"); doReturn(24'h0A0B0C);
    doEntry(8'h00, 24'h777777, 1, 4, "R6"); doReturn(24'h777777);

    // R1: multi-cycle instruction, no boundary, no acceptance
    @(negedge clk); irqReq = 8'h08; pendModel |= 8'h08;
    @(negedge clk); irqReq = '0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check(busy == 0, "R1", "busy without boundary", busy, 0);
    end
    doEntry(8'h00, 24'h3C3C3C, 0, 0, "R1"); doReturn(24'h3C3C3C);

    // R9: enable cleared, request held
    @(negedge clk); gieClr = 1;
    @(negedge clk); gieClr = 0; irqReq = 8'h02; pendModel |= 8'h02;
    @(negedge clk); irqReq = '0; instBoundary = 1;
    @(negedge clk); instBoundary = 0;
    check(busy == 0, "R9", "busy with gie low", busy, 0);
    check(gie == 0, "R9", "gie low", gie, 0);

    // R7: enable set, following instruction still runs (it enters sleep)
    @(negedge clk); instBoundary = 1; gieSet = 1;
    @(negedge clk); gieSet = 0; instBoundary = 1;
    check(gie == 1 && busy == 0, "R7", "gie set, not taken yet", busy, 0);
    @(negedge clk); instBoundary = 0;
    check(busy == 0, "R7", "shadow boundary blocked", busy, 0);
    doEntry(8'h00, 24'h5A5A01, 1, 2, "R7"); doReturn(24'h5A5A01);

    @(negedge clk);
    check(busy == 0, "R9", "idle at end", busy, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule